// File: doc/BRIEF.md
# Interrupt Event State Buffer

This block holds a two-bit P/Q state for each source in a small array of interrupt sources, and exposes it through a memory-mapped window. Software selects an operation by the address it touches, not by the data it writes. A store in the trigger range raises the source. Specific load offsets perform end-of-interrupt, read the state, or force the pair to a chosen value. Each load returns the state held before its own side effect. The read and the update happen in the same clock edge, so no other access can slip between them.

When a trigger or an end-of-interrupt finds work to hand on, the block emits a one-cycle notification carrying the source index. Routing that notification onward is the job of logic outside this block.

Each source owns a 2×4 KiB region. A source can be built so that its lower page accepts only trigger stores, while management operations live on the upper page. Per-source parameters select that split layout and whether end-of-interrupt by store is supported.

Top module: `evt_state_buf`

## Requirements
- R1: After reset every source holds P/Q = 01 (masked).
- R2: Every request cycle is answered by exactly one acknowledge in the next cycle, with read data registered alongside; no acknowledge appears without a request.
- R3: A decoded load returns the prior state with Q in bit 0, P in bit 1 and every other bit zero.
- R4: A store anywhere in offsets 0x000–0x3FF triggers the source:
  - 00 becomes 10 and emits a notification;
  - 10 and 11 become 11;
  - 01 stays 01;
  - only the 00 case notifies.
- R5: A load at offset 0x800 returns the state and leaves it unchanged.
- R6: Loads at 0xC00, 0xD00, 0xE00 and 0xF00 force P/Q to 00, 01, 10 and 11 (offset bits [9:8]) and return the prior value.
- R7: A load at offset 0x000 performs end-of-interrupt and returns the pre-EOI state:
  - with P=0 the state is untouched;
  - 10 becomes 00;
  - 11 becomes 10 and emits a notification.
- R8: A store at offset 0x400 performs the same end-of-interrupt only on sources whose STORE_EOI_EN bit is set. On other sources it is ignored.
- R9: On a source whose SPLIT_PAGE bit is set, page 0 (address bit 12 = 0) decodes only trigger stores. Every other access there is ignored. Page 1 decodes all operations. On other sources the page bit is ignored.
- R10: Undecoded offsets and stores to load-only offsets leave the state unchanged and emit no notification. They, and every store, read back as all-ones.
- R11: A notification is a single-cycle pulse of notify_valid, coincident with the acknowledge of the access that caused it. It carries the source index on notify_src.
- R12: The address is {source index, page bit, 12-bit offset}. An index at or above NUM_SRC is undecoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 15 | {source index, page bit, offset} |
| bus_wdata | input | 64 | Store data (ignored) |
| bus_ack | output | 1 | Response valid, one cycle after request |
| bus_rdata | output | 64 | Prior P/Q on decoded loads, else all-ones |
| notify_valid | output | 1 | Notification pulse |
| notify_src | output | 2 | Source index of the notification |

## Verification
The bench models every source and sweeps each source through all four starting states under every operation, comparing the returned old value, the notification and a follow-up query.

- **Trigger and EOI transitions.** A design that triggered out of the masked state would notify where none is due. One that cleared Q on end-of-interrupt without re-raising P would silently drop a pending event.
- **Page and offset decoding.** Page-0 management loads on split sources, store-EOI on unsupported sources, stores to load offsets, offsets with stray low bits and an out-of-range index are all probed. A loose decoder would alter state there, notify, or return something other than all-ones.
- **Returned value.** Force loads that returned the new value instead of the old would break the bench's re-trigger test on bit 0.

// File: rtl/evt_state_pkg.sv
// Package: shared operation codes and the P/Q next-state function.
// Assumes the P/Q pair is packed as {P, Q}.
package evt_state_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_TRIGGER = 3'd1,
        OP_EOI     = 3'd2,
        OP_QUERY   = 3'd3,
        OP_FORCE   = 3'd4
    } evt_op_e;

    typedef struct packed {
        logic [1:0] pq;
        logic       fire;
    } evt_step_t;

    // Next state and notification for one operation on one source.
    function automatic evt_step_t evt_next(evt_op_e op, logic [1:0] cur, logic [1:0] val);
        evt_step_t r;
        r.pq   = cur;
        r.fire = 1'b0;
        case (op)
            OP_TRIGGER: begin
                if (cur == 2'b00) begin
                    r.pq   = 2'b10;
                    r.fire = 1'b1;
                end else if (cur[1]) begin
                    r.pq = 2'b11;
                end
            end
            OP_EOI: begin
                if (cur == 2'b11) begin
                    r.pq   = 2'b10;
                    r.fire = 1'b1;
                end else if (cur == 2'b10) begin
                    r.pq = 2'b00;
                end
            end
            OP_FORCE: r.pq = val;
            default:  r.pq = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evt_state_decode.sv
// Module: address decoder.
// Turns one bus request into a source index and an operation, applying
// the per-source split-page and store-EOI options.
// Assumes address layout {index, page, 12-bit offset}.
module evt_state_decode
    import evt_state_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SRC_W = 2,
    parameter int OFF_W = 12,
    parameter int ADDR_W = SRC_W + 1 + OFF_W,
    parameter logic [NUM_SRC-1:0] STORE_EOI_EN = '1,
    parameter logic [NUM_SRC-1:0] SPLIT_PAGE = '0
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SRC_W-1:0]  src,
    output evt_op_e           op,
    output logic [1:0]        force_val
);

    logic [OFF_W-1:0] off;
    logic             page;
    logic             in_range;
    logic             split_bit;
    logic             seoi_bit;
    evt_op_e          raw_op;

    assign src       = addr[ADDR_W-1 -: SRC_W];
    assign page      = addr[OFF_W];
    assign off       = addr[OFF_W-1:0];
    assign force_val = off[9:8];

    // Look up the per-source options without indexing past NUM_SRC.
    always_comb begin
        in_range  = 1'b0;
        split_bit = 1'b0;
        seoi_bit  = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src == SRC_W'(i)) begin
                in_range  = 1'b1;
                split_bit = SPLIT_PAGE[i];
                seoi_bit  = STORE_EOI_EN[i];
            end
        end
    end

    // Select the operation from offset bits [11:10] and the direction.
    always_comb begin
        raw_op = OP_NONE;
        case (off[11:10])
            2'b00: begin
                if (we)
                    raw_op = OP_TRIGGER;
                else if (off[9:0] == 10'd0)
                    raw_op = OP_EOI;
            end
            2'b01: if (we && off[9:0] == 10'd0 && seoi_bit) raw_op = OP_EOI;
            2'b10: if (!we && off[9:0] == 10'd0) raw_op = OP_QUERY;
            default: if (!we && off[7:0] == 8'd0) raw_op = OP_FORCE;
        endcase
    end

    // Apply request, range and page-0 restriction.
    always_comb begin
        op = OP_NONE;
        if (req && in_range) begin
            if (split_bit && !page && raw_op != OP_TRIGGER)
                op = OP_NONE;
            else
                op = raw_op;
        end
        hit = (op != OP_NONE);
    end

endmodule

// File: rtl/evt_state_cell.sv
// Module: one source's P/Q state register.
// Updates on a selected, decoded operation and reports whether that
// operation produces a notification.
// Assumes op is OP_NONE unless a decoded access targets this source.
module evt_state_cell
    import evt_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  evt_op_e    op,
    input  logic [1:0] force_val,
    output logic [1:0] pq,
    output logic       fire
);

    evt_step_t step;

    // Compute the next state for the current operation.
    always_comb step = evt_next(op, pq, force_val);

    assign fire = sel & step.fire;

    // Hold the state; reset to masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pq <= 2'b01;
        else if (sel)
            pq <= step.pq;
    end

endmodule

// File: rtl/evt_state_buf.sv
// Module: interrupt event state buffer, top level.
// Decodes each bus access, applies it to one source cell in the same
// edge it reads the old state (atomic), and registers the response and
// any notification one cycle after the request.
// Assumes one request per cycle at most and no back-pressure.
module evt_state_buf
    import evt_state_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W = 64,
    parameter logic [NUM_SRC-1:0] STORE_EOI_EN = '1,
    parameter logic [NUM_SRC-1:0] SPLIT_PAGE = '0,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int OFF_W = 12,
    localparam int ADDR_W = SRC_W + 1 + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              notify_valid,
    output logic [SRC_W-1:0]  notify_src
);

    logic             hit;
    logic [SRC_W-1:0] src;
    evt_op_e          op;
    logic [1:0]       force_val;
    logic [1:0]       pq_q [NUM_SRC];
    logic [NUM_SRC-1:0] fire_c;
    logic [1:0]       old_pq;
    logic [DATA_W-1:0] rdata_d;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    evt_state_decode #(
        .NUM_SRC     (NUM_SRC),
        .SRC_W       (SRC_W),
        .OFF_W       (OFF_W),
        .ADDR_W      (ADDR_W),
        .STORE_EOI_EN(STORE_EOI_EN),
        .SPLIT_PAGE  (SPLIT_PAGE)
    ) u_dec (
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .hit      (hit),
        .src      (src),
        .op       (op),
        .force_val(force_val)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        logic    sel_g;
        evt_op_e op_g;
        assign sel_g = hit && (src == SRC_W'(g));
        assign op_g  = sel_g ? op : OP_NONE;
        evt_state_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel_g),
            .op       (op_g),
            .force_val(force_val),
            .pq       (pq_q[g]),
            .fire     (fire_c[g])
        );
    end

    // Pick the addressed source's state before update.
    always_comb begin
        old_pq = 2'b00;
        for (int i = 0; i < NUM_SRC; i++)
            if (src == SRC_W'(i)) old_pq = pq_q[i];
    end

    // Form read data: old state for decoded loads, all-ones otherwise.
    always_comb begin
        if (hit && !bus_we)
            rdata_d = {{(DATA_W-2){1'b0}}, old_pq};
        else
            rdata_d = '1;
    end

    // Register the response and the notification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack      <= 1'b0;
            bus_rdata    <= '1;
            notify_valid <= 1'b0;
            notify_src   <= '0;
        end else begin
            bus_ack      <= bus_req;
            bus_rdata    <= rdata_d;
            notify_valid <= |fire_c;
            notify_src   <= (|fire_c) ? src : notify_src;
        end
    end

endmodule

// File: rtl/evt_state_buf_checker.sv
// Module: protocol checker for evt_state_buf, attached by bind.
// Assumes the bound instance uses synchronous active-low reset.
module evt_state_buf_checker #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W = 2,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              notify_valid,
    input logic [SRC_W-1:0]  notify_src
);

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);

    assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);

    assert_notify_with_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> bus_ack);

    assert_notify_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid && !bus_req |=> !notify_valid);

    assert_notify_index_R12: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (int'(notify_src) < NUM_SRC));

    assert_load_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !(&bus_rdata)) |-> (bus_rdata[DATA_W-1:2] == '0));

endmodule

bind evt_state_buf evt_state_buf_checker #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .notify_valid(notify_valid),
    .notify_src  (notify_src)
);

// File: tb/evt_state_buf_test.sv
`timescale 1ns/100ps
module evt_state_buf_test;

    localparam int NSRC = 3;
    localparam int SW = 2;
    localparam int AW = SW + 13;
    localparam logic [2:0] SEOI = 3'b101;
    localparam logic [2:0] SPLIT = 3'b011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic          bus_ack;
    logic [63:0]   bus_rdata;
    logic          notify_valid;
    logic [SW-1:0] notify_src;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [1:0] model [4];

    always #2.5 clk = ~clk;

    evt_state_buf #(
        .NUM_SRC(NSRC), .DATA_W(64), .STORE_EOI_EN(SEOI), .SPLIT_PAGE(SPLIT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .notify_valid(notify_valid), .notify_src(notify_src)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Operation from the requirements: 0 none, 1 trigger, 2 eoi, 3 query, 4 force.
    function automatic int mdecode(int s, int pg, int off, bit we);
        int k;
        k = 0;
        if (s >= NSRC) return 0;
        case (off >> 10)
            0: k = we ? 1 : ((off == 0) ? 2 : 0);
            1: k = (we && off == 12'h400 && SEOI[s]) ? 2 : 0;
            2: k = (!we && off == 12'h800) ? 3 : 0;
            default: k = (!we && (off & 8'hFF) == 0) ? 4 : 0;
        endcase
        if (SPLIT[s] && pg == 0 && k != 1) k = 0;
        return k;
    endfunction

    // One access; checks response, data and notification against the model.
    task automatic access(string tag, bit we, int s, int pg, int off);
        int k;
        logic [1:0] old;
        logic [1:0] nxt;
        bit fire;
        logic [63:0] exp;
        k = mdecode(s, pg, off, we);
        old = model[s];
        nxt = old;
        fire = 1'b0;
        if (k == 1) begin
            if (old == 2'b00) begin nxt = 2'b10; fire = 1'b1; end
            else if (old[1]) nxt = 2'b11;
        end else if (k == 2) begin
            if (old == 2'b11) begin nxt = 2'b10; fire = 1'b1; end
            else if (old == 2'b10) nxt = 2'b00;
        end else if (k == 4) begin
            nxt = 2'((off >> 8) & 3);
        end
        exp = (k != 0 && !we) ? {62'd0, old} : '1;
        bus_req = 1'b1;
        bus_we = we;
        bus_addr = {SW'(s), 1'(pg), 12'(off)};
        bus_wdata = 64'hA5A5_0000_0000_5A5A;
        @(negedge clk);
        bus_req = 1'b0;
        chk({tag, " R2 ack"}, {63'd0, bus_ack}, 64'd1);
        chk({tag, " rdata"}, bus_rdata, exp);
        chk({tag, " R11 notify"}, {63'd0, notify_valid}, {63'd0, fire});
        if (fire) chk({tag, " R11 notify_src"}, {62'd0, notify_src}, 64'(s));
        if (s < NSRC) model[s] = nxt;
    endtask

    task automatic query_all(string tag);
        for (int s = 0; s < NSRC; s++) access(tag, 1'b0, s, 1, 12'h800);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) model[s] = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle ack", {63'd0, bus_ack}, 64'd0);
        // R1: reset state is masked, read by R5 queries.
        query_all("R1 reset");

        // R4 R5 R6 R7 R8: every op from every starting state on page 1.
        for (int s = 0; s < NSRC; s++) begin
            for (int st = 0; st < 4; st++) begin
                for (int op = 0; op < 8; op++) begin
                    access("R6 force start", 1'b0, s, 1, 12'hC00 + st * 256);
                    case (op)
                        0: access("R4 trigger", 1'b1, s, 1, 12'h000);
                        1: access("R7 load eoi", 1'b0, s, 1, 12'h000);
                        2: access("R8 store eoi", 1'b1, s, 1, 12'h400);
                        3: access("R5 query", 1'b0, s, 1, 12'h800);
                        default: access("R6 force", 1'b0, s, 1, 12'hC00 + (op - 4) * 256);
                    endcase
                    access("R5 followup", 1'b0, s, 1, 12'h800);
                end
            end
        end

        // R4: trigger anywhere in the store range, from the idle state.
        for (int s = 0; s < NSRC; s++) begin
            access("R6 unmask", 1'b0, s, 1, 12'hC00);
            access("R4 trigger 3FF", 1'b1, s, 1, 12'h3FF);
            access("R4 trigger 123", 1'b1, s, 1, 12'h123);
            access("R7 eoi retrig", 1'b0, s, 1, 12'h000);
            access("R5 followup", 1'b0, s, 1, 12'h800);
        end

        // R9: page-0 accesses on split and unsplit sources.
        for (int s = 0; s < NSRC; s++) begin
            access("R6 set 11", 1'b0, s, 1, 12'hF00);
            access("R9 p0 eoi", 1'b0, s, 0, 12'h000);
            access("R9 p0 query", 1'b0, s, 0, 12'h800);
            access("R9 p0 force", 1'b0, s, 0, 12'hC00);
            access("R9 p0 store eoi", 1'b1, s, 0, 12'h400);
            access("R9 p0 trigger", 1'b1, s, 0, 12'h010);
            access("R9 followup", 1'b0, s, 1, 12'h800);
        end

        // R10: undecoded loads and stores to load-only offsets.
        for (int s = 0; s < NSRC; s++) begin
            access("R6 set 10", 1'b0, s, 1, 12'hE00);
            access("R10 load 004", 1'b0, s, 1, 12'h004);
            access("R10 load 400", 1'b0, s, 1, 12'h400);
            access("R10 load 804", 1'b0, s, 1, 12'h804);
            access("R10 load C04", 1'b0, s, 1, 12'hC04);
            access("R10 store 800", 1'b1, s, 1, 12'h800);
            access("R10 store C00", 1'b1, s, 1, 12'hC00);
            access("R10 store 404", 1'b1, s, 1, 12'h404);
            access("R10 followup", 1'b0, s, 1, 12'h800);
        end

        // R12: index beyond the populated sources is undecoded.
        access("R12 oor trigger", 1'b1, 3, 1, 12'h000);
        access("R12 oor query", 1'b0, 3, 1, 12'h800);
        access("R12 oor force", 1'b0, 3, 0, 12'hC00);
        query_all("R12 others intact");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule